// File: doc/BRIEF.md
# Load Issue Memory Disambiguation Gate

This block sits beside the load scheduler of an out-of-order core and decides whether a load may issue while older stores are still in flight. It keeps every dispatched store in an eight-entry queue in program order and records, per store, whether its address has been computed and what that address is. A load's dependence on older stores cannot be known until all of those stores have computed their addresses. A younger load can have its own address ready well before that happens, and the gate resolves this conflict under one of two policies.

With `aggrMode` low (conservative), a load is granted only when every store older than it has a known address. A ready load with an older resolved store at the same address is still granted and raises a match flag for the forwarding logic. With `aggrMode` high (aggressive), a load is assumed independent of stores with unknown addresses and is granted at once. Its address and age are kept in a tracking slot the scheduler names. When an older store later resolves to that address, the slot is reported as misspeculated. Each load carries the queue tail pointer it saw at dispatch. Every store between the queue head and that pointer is older than the load. Stores leave at retirement in order, and a flush cuts away every store younger than a given entry.

The environment guarantees the following. A store resolves only while live. A flush names a live entry. A load's tracking slot is released before any store younger than that load retires.

Top module: `load_issue_gate`

## Requirements
- R1: After reset the queue is empty: `sqTail` is 0, `sqFull` is 0 and `violMask` is 0.
- R2: `stAllocValid` with room and no flush writes a new unresolved store at queue entry `sqTail[2:0]` and advances the 4-bit pointer `sqTail` (bit 3 is the wrap bit) by one on the next edge. Without allocation or flush, `sqTail` holds.
- R3: `stRetireValid` frees the head store only if its address is resolved. A retire request on an unresolved head store is ignored.
- R4: With `aggrMode` low, `ldGrant` is high only when `ldValid` is high and no live store between the head and `ldTail` is unresolved. A load whose `ldTail` equals the head has no older stores and is granted.
- R5: With `aggrMode` high, `ldGrant` equals `ldValid` whatever the state of older stores.
- R6: `ldFwdMatch` is high when `ldValid` is high and an older resolved store holds an address equal to `ldAddr`. Younger stores and stores with other addresses do not raise it.
- R7: In aggressive mode a load is recorded in slot `ldSlot`. If an older store later resolves to the recorded address, bit `ldSlot` of `violMask` rises on the edge after the resolve and stays high for one cycle only.
- R8: A resolve in the same cycle as the aggressive issue of a younger load with the same address flags that load's slot.
- R9: A resolve does not flag a load whose slot has been released, or a load that is older than the resolving store.
- R10: `flushValid` with entry `flushIdx` removes every store younger than that entry. `sqTail` becomes the pointer just after it, and an allocation in the same cycle is ignored.
- R11: `sqFull` is high exactly when eight stores are live. An allocation request while full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aggrMode | input | 1 | 1 = aggressive policy, 0 = conservative |
| stAllocValid | input | 1 | Dispatch a store at the tail |
| sqTail | output | 4 | Tail pointer with wrap bit, captured by loads |
| sqFull | output | 1 | Eight stores live |
| stResolveValid | input | 1 | A store address has been computed |
| stResolveIdx | input | 3 | Queue entry of the resolving store |
| stResolveAddr | input | ADDR_W | Computed store address |
| stRetireValid | input | 1 | Retire the head store |
| flushValid | input | 1 | Drop stores younger than `flushIdx` |
| flushIdx | input | 3 | Youngest queue entry that survives |
| ldValid | input | 1 | A load asks to issue |
| ldAddr | input | ADDR_W | Load address |
| ldTail | input | 4 | Tail pointer seen by the load at dispatch |
| ldSlot | input | 2 | Tracking slot of the load |
| ldGrant | output | 1 | Load may issue |
| ldFwdMatch | output | 1 | Older resolved store at the same address |
| ldReleaseValid | input | 1 | Free a tracking slot |
| ldReleaseSlot | input | 2 | Slot to free |
| violMask | output | LD_SLOTS | One-cycle misspeculation flag per slot |

## Verification
A store resolve and the aggressive issue of a younger load at the same address can fall in the same cycle. In that cycle the load is not yet in its slot, so the resolve must be compared with the incoming load as well as with the stored slots. The bench drives both in one cycle and expects the slot bit in `violMask` on the next. A flush and an allocation can also coincide. Here the bench judges the resulting tail pointer and the room left, filling the queue until `sqFull` rises.

// File: rtl/load_issue_gate_pkg.sv
package load_issue_gate_pkg;
  localparam int SQ_DEPTH = 8;
  localparam int SQ_IDX_W = $clog2(SQ_DEPTH);
  localparam int SQ_PTR_W = SQ_IDX_W + 1;

  typedef logic [SQ_IDX_W-1:0] sqIdx_t;
  typedef logic [SQ_PTR_W-1:0] sqPtr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                allocEn;
    sqIdx_t              allocIdx;
    logic                retireEn;
    sqIdx_t              retireIdx;
    logic [SQ_DEPTH-1:0] clrMask;
    logic                recordEn;
    sqPtr_t              headPtr;
  } ctrlStrobe_t;
endpackage

// File: rtl/lig_ctrl.sv
module lig_ctrl
  import load_issue_gate_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                aggrMode,
  input  logic                stAllocValid,
  input  logic                stRetireValid,
  input  logic                flushValid,
  input  sqIdx_t              flushIdx,
  input  logic                ldValid,
  input  logic [SQ_DEPTH-1:0] sqResolved,
  output ctrlStrobe_t         strobe,
  output sqPtr_t              sqTail,
  output logic                sqFull
);
  sqPtr_t headPtr, tailPtr, liveCount, flushTail, tailNext;
  sqIdx_t headIdx, flushDist;
  logic   qEmpty, allocEn, retireEn;
  logic [SQ_DEPTH-1:0] clrMask;

  assign headIdx   = headPtr[SQ_IDX_W-1:0];
  assign liveCount = tailPtr - headPtr;
  assign sqFull    = (liveCount == sqPtr_t'(SQ_DEPTH));
  assign qEmpty    = (liveCount == '0);
  assign flushDist = flushIdx - headIdx;
  assign flushTail = headPtr + sqPtr_t'(flushDist) + sqPtr_t'(1);

  assign allocEn  = stAllocValid && !sqFull && !flushValid;
  assign retireEn = stRetireValid && !qEmpty && sqResolved[headIdx];

  // entries further from the head than the flush point are cut
  for (genvar i = 0; i < SQ_DEPTH; i++) begin : g_clr
    sqIdx_t entDist;
    assign entDist    = sqIdx_t'(i) - headIdx;
    assign clrMask[i] = flushValid && (entDist > flushDist);
  end

  always_comb begin
    tailNext = tailPtr;
    if (flushValid)   tailNext = flushTail;
    else if (allocEn) tailNext = tailPtr + sqPtr_t'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      tailPtr <= tailNext;
      if (retireEn) headPtr <= headPtr + sqPtr_t'(1);
    end
  end

  always_comb begin
    strobe.allocEn   = allocEn;
    strobe.allocIdx  = tailPtr[SQ_IDX_W-1:0];
    strobe.retireEn  = retireEn;
    strobe.retireIdx = headIdx;
    strobe.clrMask   = clrMask;
    strobe.recordEn  = ldValid && aggrMode;
    strobe.headPtr   = headPtr;
  end

  assign sqTail = tailPtr;
endmodule

// File: rtl/lig_dpath.sv
module lig_dpath
  import load_issue_gate_pkg::*;
#(
  parameter  int ADDR_W    = 16,
  parameter  int LD_SLOTS  = 4,
  localparam int LD_SLOT_W = $clog2(LD_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobe_t          strobe,
  input  logic                 aggrMode,
  input  logic                 stResolveValid,
  input  sqIdx_t               stResolveIdx,
  input  logic [ADDR_W-1:0]    stResolveAddr,
  input  logic                 ldValid,
  input  logic [ADDR_W-1:0]    ldAddr,
  input  sqPtr_t               ldTail,
  input  logic [LD_SLOT_W-1:0] ldSlot,
  input  logic                 ldReleaseValid,
  input  logic [LD_SLOT_W-1:0] ldReleaseSlot,
  output logic [SQ_DEPTH-1:0]  sqResolved,
  output logic                 ldGrant,
  output logic                 ldFwdMatch,
  output logic [LD_SLOTS-1:0]  violMask
);
  logic [SQ_DEPTH-1:0] sqValid, sqRes, olderVec, addrEqVec;
  logic [ADDR_W-1:0]   sqAddr [SQ_DEPTH];
  logic [LD_SLOTS-1:0] slotValid, violNext;
  logic [ADDR_W-1:0]   slotAddr [LD_SLOTS];
  sqPtr_t              slotTail [LD_SLOTS];

  sqIdx_t headIdx;
  sqPtr_t loadSpan, resDist;
  logic   resolveHit;

  assign headIdx    = strobe.headPtr[SQ_IDX_W-1:0];
  assign loadSpan   = ldTail - strobe.headPtr;
  assign resDist    = sqPtr_t'(sqIdx_t'(stResolveIdx - headIdx));
  assign resolveHit = stResolveValid && sqValid[stResolveIdx] && !strobe.clrMask[stResolveIdx];

  // store queue entries
  for (genvar i = 0; i < SQ_DEPTH; i++) begin : g_sq
    sqIdx_t entDist;
    assign entDist      = sqIdx_t'(i) - headIdx;
    assign olderVec[i]  = sqValid[i] && (sqPtr_t'(entDist) < loadSpan);
    assign addrEqVec[i] = (sqAddr[i] == ldAddr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sqValid[i] <= 1'b0;
        sqRes[i]   <= 1'b0;
        sqAddr[i]  <= '0;
      end else if (strobe.clrMask[i]) begin
        sqValid[i] <= 1'b0;
        sqRes[i]   <= 1'b0;
      end else if (strobe.allocEn && strobe.allocIdx == sqIdx_t'(i)) begin
        sqValid[i] <= 1'b1;
        sqRes[i]   <= 1'b0;
      end else if (strobe.retireEn && strobe.retireIdx == sqIdx_t'(i)) begin
        sqValid[i] <= 1'b0;
        sqRes[i]   <= 1'b0;
      end else if (resolveHit && stResolveIdx == sqIdx_t'(i)) begin
        sqRes[i]  <= 1'b1;
        sqAddr[i] <= stResolveAddr;
      end
    end
  end

  assign sqResolved = sqValid & sqRes;
  assign ldGrant    = ldValid && (aggrMode || !(|(olderVec & ~sqRes)));
  assign ldFwdMatch = ldValid && (|(olderVec & sqRes & addrEqVec));

  // speculatively issued load tracking
  for (genvar j = 0; j < LD_SLOTS; j++) begin : g_slot
    logic takeNew, hitOld, hitNew;
    assign takeNew = strobe.recordEn && (ldSlot == LD_SLOT_W'(j));
    assign hitOld  = slotValid[j] && !takeNew && (slotAddr[j] == stResolveAddr)
                     && (resDist < (slotTail[j] - strobe.headPtr));
    assign hitNew  = takeNew && (ldAddr == stResolveAddr) && (resDist < loadSpan);
    assign violNext[j] = resolveHit && (hitOld || hitNew);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slotValid[j] <= 1'b0;
        slotAddr[j]  <= '0;
        slotTail[j]  <= '0;
      end else if (takeNew) begin
        slotValid[j] <= 1'b1;
        slotAddr[j]  <= ldAddr;
        slotTail[j]  <= ldTail;
      end else if (ldReleaseValid && ldReleaseSlot == LD_SLOT_W'(j)) begin
        slotValid[j] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) violMask <= '0;
    else        violMask <= violNext;
  end
endmodule

// File: rtl/load_issue_gate.sv
module load_issue_gate
  import load_issue_gate_pkg::*;
#(
  parameter  int ADDR_W    = 16,
  parameter  int LD_SLOTS  = 4,
  localparam int LD_SLOT_W = $clog2(LD_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 aggrMode,
  input  logic                 stAllocValid,
  output logic [SQ_PTR_W-1:0]  sqTail,
  output logic                 sqFull,
  input  logic                 stResolveValid,
  input  logic [SQ_IDX_W-1:0]  stResolveIdx,
  input  logic [ADDR_W-1:0]    stResolveAddr,
  input  logic                 stRetireValid,
  input  logic                 flushValid,
  input  logic [SQ_IDX_W-1:0]  flushIdx,
  input  logic                 ldValid,
  input  logic [ADDR_W-1:0]    ldAddr,
  input  logic [SQ_PTR_W-1:0]  ldTail,
  input  logic [LD_SLOT_W-1:0] ldSlot,
  output logic                 ldGrant,
  output logic                 ldFwdMatch,
  input  logic                 ldReleaseValid,
  input  logic [LD_SLOT_W-1:0] ldReleaseSlot,
  output logic [LD_SLOTS-1:0]  violMask
);
  ctrlStrobe_t         strobe;
  logic [SQ_DEPTH-1:0] sqResolved;

  lig_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .aggrMode     (aggrMode),
    .stAllocValid (stAllocValid),
    .stRetireValid(stRetireValid),
    .flushValid   (flushValid),
    .flushIdx     (flushIdx),
    .ldValid      (ldValid),
    .sqResolved   (sqResolved),
    .strobe       (strobe),
    .sqTail       (sqTail),
    .sqFull       (sqFull)
  );

  lig_dpath #(.ADDR_W(ADDR_W), .LD_SLOTS(LD_SLOTS)) dpath_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .aggrMode      (aggrMode),
    .stResolveValid(stResolveValid),
    .stResolveIdx  (stResolveIdx),
    .stResolveAddr (stResolveAddr),
    .ldValid       (ldValid),
    .ldAddr        (ldAddr),
    .ldTail        (ldTail),
    .ldSlot        (ldSlot),
    .ldReleaseValid(ldReleaseValid),
    .ldReleaseSlot (ldReleaseSlot),
    .sqResolved    (sqResolved),
    .ldGrant       (ldGrant),
    .ldFwdMatch    (ldFwdMatch),
    .violMask      (violMask)
  );
endmodule

// File: rtl/lig_checker.sv
module lig_checker
  import load_issue_gate_pkg::*;
#(
  parameter int LD_SLOTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                aggrMode,
  input logic                stAllocValid,
  input logic [SQ_PTR_W-1:0] sqTail,
  input logic                sqFull,
  input logic                stResolveValid,
  input logic                flushValid,
  input logic                ldValid,
  input logic                ldGrant,
  input logic [LD_SLOTS-1:0] violMask
);
  AST_AGGR_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (aggrMode && ldValid) |-> ldGrant); // R5

  AST_NO_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !ldValid |-> !ldGrant); // R4

  AST_TAIL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (stAllocValid && !sqFull && !flushValid) |=> (sqTail == SQ_PTR_W'($past(sqTail) + 1'b1))); // R2

  AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stAllocValid && !flushValid) |=> $stable(sqTail)); // R2

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sqFull && !flushValid) |=> $stable(sqTail)); // R11

  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !stResolveValid |=> (violMask == '0)); // R7
endmodule

bind load_issue_gate lig_checker #(.LD_SLOTS(LD_SLOTS)) chk_i (.*);

// File: tb/load_issue_gate_tb_top.sv
module load_issue_gate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        aggrMode, stAllocValid, stResolveValid, stRetireValid, flushValid;
  logic [2:0]  stResolveIdx, flushIdx;
  logic [15:0] stResolveAddr, ldAddr;
  logic        ldValid, ldReleaseValid;
  logic [3:0]  ldTail;
  logic [1:0]  ldSlot, ldReleaseSlot;
  logic [3:0]  sqTail;
  logic        sqFull, ldGrant, ldFwdMatch;
  logic [3:0]  violMask;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_issue_gate dut_i (
    .clk(clk), .rst_n(rst_n), .aggrMode(aggrMode), .stAllocValid(stAllocValid),
    .sqTail(sqTail), .sqFull(sqFull), .stResolveValid(stResolveValid),
    .stResolveIdx(stResolveIdx), .stResolveAddr(stResolveAddr),
    .stRetireValid(stRetireValid), .flushValid(flushValid), .flushIdx(flushIdx),
    .ldValid(ldValid), .ldAddr(ldAddr), .ldTail(ldTail), .ldSlot(ldSlot),
    .ldGrant(ldGrant), .ldFwdMatch(ldFwdMatch), .ldReleaseValid(ldReleaseValid),
    .ldReleaseSlot(ldReleaseSlot), .violMask(violMask)
  );

  typedef struct packed {
    logic        aggr;
    logic        alloc;
    logic        resV;
    logic [2:0]  resIdx;
    logic [15:0] resAddr;
    logic        ldV;
    logic [15:0] lAddr;
    logic [3:0]  lTail;
    logic [1:0]  lSlot;
    logic        relV;
    logic [1:0]  relSlot;
    logic [3:0]  eTail;
    logic        eFull;
    logic        eGrant;
    logic        eFwd;
    logic [3:0]  eViol;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    // aggr alloc resV resIdx resAddr ldV ldAddr ldTail ldSlot relV relSlot | eTail eFull eGrant eFwd eViol req
    '{1'b0,1'b1,1'b0,3'd0,16'h0000,1'b0,16'h0000,4'd0,2'd0,1'b0,2'd0, 4'd0,1'b0,1'b0,1'b0,4'h0,8'd2}, // R2
    '{1'b0,1'b1,1'b0,3'd0,16'h0000,1'b1,16'h0040,4'd1,2'd0,1'b0,2'd0, 4'd1,1'b0,1'b0,1'b0,4'h0,8'd4}, // R4 older unresolved
    '{1'b0,1'b0,1'b1,3'd0,16'h0040,1'b1,16'h0040,4'd1,2'd0,1'b0,2'd0, 4'd2,1'b0,1'b0,1'b0,4'h0,8'd4}, // R4 resolve not yet seen
    '{1'b0,1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0040,4'd1,2'd0,1'b0,2'd0, 4'd2,1'b0,1'b1,1'b1,4'h0,8'd6}, // R6 match
    '{1'b0,1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0040,4'd2,2'd0,1'b0,2'd0, 4'd2,1'b0,1'b0,1'b1,4'h0,8'd4}, // R4 second older open
    '{1'b0,1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0044,4'd1,2'd0,1'b0,2'd0, 4'd2,1'b0,1'b1,1'b0,4'h0,8'd6}, // R6 other address
    '{1'b1,1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0050,4'd2,2'd1,1'b0,2'd0, 4'd2,1'b0,1'b1,1'b0,4'h0,8'd5}, // R5 speculative issue
    '{1'b1,1'b0,1'b1,3'd1,16'h0050,1'b0,16'h0000,4'd0,2'd0,1'b0,2'd0, 4'd2,1'b0,1'b0,1'b0,4'h0,8'd7}, // R7 resolve
    '{1'b1,1'b0,1'b0,3'd0,16'h0000,1'b0,16'h0000,4'd0,2'd0,1'b0,2'd0, 4'd2,1'b0,1'b0,1'b0,4'h2,8'd7}, // R7 flagged
    '{1'b1,1'b1,1'b0,3'd0,16'h0000,1'b0,16'h0000,4'd0,2'd0,1'b0,2'd0, 4'd2,1'b0,1'b0,1'b0,4'h0,8'd7}, // R7 one cycle
    '{1'b1,1'b0,1'b0,3'd0,16'h0000,1'b1,16'h0060,4'd2,2'd2,1'b0,2'd0, 4'd3,1'b0,1'b1,1'b0,4'h0,8'd5}, // R5
    '{1'b1,1'b0,1'b1,3'd2,16'h0060,1'b0,16'h0000,4'd0,2'd0,1'b0,2'd0, 4'd3,1'b0,1'b0,1'b0,4'h0,8'd9}, // R9 younger store
    '{1'b1,1'b1,1'b0,3'd0,16'h0000,1'b0,16'h0000,4'd0,2'd0,1'b1,2'd1, 4'd3,1'b0,1'b0,1'b0,4'h0,8'd9}, // R9 no flag
    '{1'b1,1'b0,1'b1,3'd3,16'h0070,1'b1,16'h0070,4'd4,2'd0,1'b0,2'd0, 4'd4,1'b0,1'b1,1'b0,4'h0,8'd8}, // R8 same cycle
    '{1'b1,1'b0,1'b0,3'd0,16'h0000,1'b0,16'h0000,4'd0,2'd0,1'b0,2'd0, 4'd4,1'b0,1'b0,1'b0,4'h1,8'd8}  // R8 flagged
  };

  task automatic check(input string tag, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearIns();
    aggrMode = 1'b0; stAllocValid = 1'b0; stResolveValid = 1'b0; stResolveIdx = '0;
    stResolveAddr = '0; stRetireValid = 1'b0; flushValid = 1'b0; flushIdx = '0;
    ldValid = 1'b0; ldAddr = '0; ldTail = '0; ldSlot = '0;
    ldReleaseValid = 1'b0; ldReleaseSlot = '0;
  endtask

  task automatic nextCycle();
    @(negedge clk);
    clearIns();
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish();
    end
  end

  initial begin
    clearIns();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    // R1 reset state (also R4: empty queue grants)
    @(negedge clk);
    ldValid = 1'b1; ldTail = 4'd0;
    #1;
    check("R1 tail", sqTail, 0);
    check("R1 full", sqFull, 0);
    check("R1 viol", violMask, 0);
    rst_n = 1'b1;
    #1;
    check("R4 empty grant", ldGrant, 1);

    for (int k = 0; k < NVEC; k++) begin
      nextCycle();
      aggrMode = VEC[k].aggr; stAllocValid = VEC[k].alloc;
      stResolveValid = VEC[k].resV; stResolveIdx = VEC[k].resIdx; stResolveAddr = VEC[k].resAddr;
      ldValid = VEC[k].ldV; ldAddr = VEC[k].lAddr; ldTail = VEC[k].lTail; ldSlot = VEC[k].lSlot;
      ldReleaseValid = VEC[k].relV; ldReleaseSlot = VEC[k].relSlot;
      #1;
      check($sformatf("R%0d vec%0d tail", VEC[k].req, k), sqTail, VEC[k].eTail);
      check($sformatf("R%0d vec%0d full", VEC[k].req, k), sqFull, VEC[k].eFull);
      check($sformatf("R%0d vec%0d grant", VEC[k].req, k), ldGrant, VEC[k].eGrant);
      check($sformatf("R%0d vec%0d fwd", VEC[k].req, k), ldFwdMatch, VEC[k].eFwd);
      check($sformatf("R%0d vec%0d viol", VEC[k].req, k), violMask, VEC[k].eViol);
    end

    // free remaining slots
    nextCycle(); ldReleaseValid = 1'b1; ldReleaseSlot = 2'd0;
    nextCycle(); ldReleaseValid = 1'b1; ldReleaseSlot = 2'd2;

    // R11: fill to eight live stores (head 0, tail 4)
    for (int k = 0; k < 4; k++) begin nextCycle(); stAllocValid = 1'b1; end
    nextCycle(); stAllocValid = 1'b1; #1;
    check("R11 full", sqFull, 1);
    check("R11 tail", sqTail, 8);
    nextCycle(); #1;
    check("R11 alloc ignored", sqTail, 8);

    // R3: retire four resolved, then try unresolved head (entry 4)
    for (int k = 0; k < 4; k++) begin nextCycle(); stRetireValid = 1'b1; end
    nextCycle(); stRetireValid = 1'b1;
    for (int k = 0; k < 4; k++) begin nextCycle(); stAllocValid = 1'b1; end
    nextCycle(); #1;
    check("R3 unresolved retire ignored full", sqFull, 1);
    check("R3 tail", sqTail, 12);
    stResolveValid = 1'b1; stResolveIdx = 3'd4; stResolveAddr = 16'h0080;
    nextCycle(); stRetireValid = 1'b1;
    nextCycle(); ldValid = 1'b1; ldTail = 4'd5; ldAddr = 16'h0080; #1;
    check("R3 resolved retire frees", sqFull, 0);
    check("R4 no older stores", ldGrant, 1);
    check("R6 retired store no match", ldFwdMatch, 0);
    nextCycle(); ldValid = 1'b1; ldTail = 4'd12; #1;
    check("R4 older unresolved", ldGrant, 0);

    // R10: keep entries 5..7, alloc in same cycle ignored
    nextCycle(); flushValid = 1'b1; flushIdx = 3'd7; stAllocValid = 1'b1;
    nextCycle(); #1;
    check("R10 tail after flush", sqTail, 8);
    check("R10 not full", sqFull, 0);
    for (int k = 0; k < 4; k++) begin nextCycle(); stAllocValid = 1'b1; end
    nextCycle(); #1;
    check("R10 seven live", sqFull, 0);
    stAllocValid = 1'b1;
    nextCycle(); #1;
    check("R10 eight live", sqFull, 1);
    check("R10 tail", sqTail, 13);

    // R9 released slot, R7 positive case
    nextCycle(); aggrMode = 1'b1; ldValid = 1'b1; ldAddr = 16'h0099; ldTail = 4'd13; ldSlot = 2'd3; #1;
    check("R5 grant with open stores", ldGrant, 1);
    nextCycle(); ldReleaseValid = 1'b1; ldReleaseSlot = 2'd3;
    ldValid = 1'b1; ldAddr = 16'h0099; ldTail = 4'd13; #1;
    check("R4 conservative hold", ldGrant, 0);
    nextCycle(); stResolveValid = 1'b1; stResolveIdx = 3'd5; stResolveAddr = 16'h0099;
    nextCycle(); #1;
    check("R9 released slot", violMask, 0);
    aggrMode = 1'b1; ldValid = 1'b1; ldAddr = 16'h0099; ldTail = 4'd13; ldSlot = 2'd3;
    nextCycle(); stResolveValid = 1'b1; stResolveIdx = 3'd6; stResolveAddr = 16'h0099;
    nextCycle(); #1;
    check("R7 late older store", violMask, 8);
    ldValid = 1'b1; ldAddr = 16'h0099; ldTail = 4'd5;
    #1;
    check("R6 younger store ignored", ldFwdMatch, 0);
    nextCycle(); ldValid = 1'b1; ldAddr = 16'h0099; ldTail = 4'd6; #1;
    check("R7 pulse ends", violMask, 0);
    check("R6 older match", ldFwdMatch, 1);

    finished = 1'b1;
    nextCycle();
    finish();
  end
endmodule